// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit performs the multiply and divide work of a 32-bit RISC core. It keeps its results in a private pair of registers, HI and LO. The core issues one request per cycle: a 4-bit operation code and two operands, qualified by a valid strobe.

A multiply finishes in the same cycle it is accepted. The 64-bit product is split so that HI receives the upper half and LO the lower half. A divide runs through an iterative restoring loop and raises a busy flag for its whole duration. When it finishes, the remainder lands in HI and the quotient in LO. Each of these operations has a signed variant and an unsigned variant.

Move operations give the core direct access to both registers. A move-to overwrites one register. A move-from returns one register on a registered read port. While busy is high, every request is refused and dropped. The core's stall logic must hold and re-present the request once busy clears, so a move-from cannot return stale data during a divide.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO are zero, busy_o is low and rd_valid_o is low.
- R2: An accepted op 1 (signed multiply) writes the upper 32 bits of the two's-complement 64-bit product of a_i and b_i to HI and the lower 32 bits to LO, at the accepting clock edge.
- R3: An accepted op 2 (unsigned multiply) does the same with both operands taken as unsigned.
- R4: An accepted op 4 (unsigned divide) with nonzero b_i raises busy_o from the next cycle for exactly 32 cycles. At the edge where busy_o falls, it writes a_i mod b_i to HI and a_i / b_i to LO.
- R5: An accepted op 3 (signed divide) with nonzero b_i uses the same timing. The quotient is rounded toward zero and the remainder takes the sign of a_i. The case 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R6: A divide (op 3 or op 4) with b_i equal to zero completes at once: busy_o stays low and HI and LO keep their values.
- R7: An accepted op 5 (read HI) or op 6 (read LO) sets rd_valid_o high for one cycle, in the cycle after acceptance, with rd_data_o holding the addressed register. rd_valid_o is low after any other operation.
- R8: An accepted op 7 writes a_i to HI only, and op 8 writes a_i to LO only.
- R9: A request is accepted only when req_valid_i is high and busy_o is low. A request made while busy_o is high changes neither HI nor LO and produces no rd_valid_o.
- R10: Op 0 and op codes 9 to 15 change neither HI nor LO and produce no rd_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code (0 none, 1..8 as in the requirements) |
| a_i | input | 32 | First operand / dividend / move-to data |
| b_i | input | 32 | Second operand / divisor |
| busy_o | output | 1 | Divide in progress; requests refused |
| rd_valid_o | output | 1 | Move-from result valid |
| rd_data_o | output | 32 | Move-from result |

## Verification
The bench builds the unit with its default width of 32. At that width the signed extremes are reachable: the most negative operand, the all-ones operand and the overflowing signed quotient. A 32-bit width also gives the full 32-cycle busy window. Values are read back only through the move-from port, so every HI/LO effect is observed at the block's own interface. Refused requests are issued inside the divide window, and each one is followed by a read-back once busy has fallen.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_MULS = 4'd1,
    OP_MULU = 4'd2,
    OP_DIVS = 4'd3,
    OP_DIVU = 4'd4,
    OP_RDHI = 4'd5,
    OP_RDLO = 4'd6,
    OP_WRHI = 4'd7,
    OP_WRLO = 4'd8
  } mdu_op_e;
endpackage

// File: rtl/hilo_mul.sv
module hilo_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         signed_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int PW = 2 * W;
  logic [PW-1:0] a_ext, b_ext, prod;

  // sign- or zero-extend to full product width; low PW bits are exact
  assign a_ext = {{W{signed_i & a_i[W-1]}}, a_i};
  assign b_ext = {{W{signed_i & b_i[W-1]}}, b_i};
  assign prod  = a_ext * b_ext;
  assign hi_o  = prod[PW-1:W];
  assign lo_o  = prod[W-1:0];
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q, neg_q_q, neg_r_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [W-1:0]  a_mag, b_mag, rem_nx, quo_nx;
  logic [W:0]    trial, diff;
  logic          fits;

  assign a_mag = (signed_i && a_i[W-1]) ? -a_i : a_i;
  assign b_mag = (signed_i && b_i[W-1]) ? -b_i : b_i;

  // one restoring step
  assign trial  = {rem_q, quo_q[W-1]};
  assign diff   = trial - {1'b0, dvs_q};
  assign fits   = ~diff[W];
  assign rem_nx = fits ? diff[W-1:0] : trial[W-1:0];
  assign quo_nx = {quo_q[W-2:0], fits};

  assign done_o = busy_q && (cnt_q == LAST);
  assign busy_o = busy_q;
  assign quo_o  = neg_q_q ? -quo_nx : quo_nx;
  assign rem_o  = neg_r_q ? -rem_nx : rem_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= a_mag;
      dvs_q   <= b_mag;
      neg_q_q <= signed_i && (a_i[W-1] ^ b_i[W-1]);
      neg_r_q <= signed_i && a_i[W-1];
    end else if (busy_q) begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
      cnt_q <= cnt_q + 1'b1;
      if (done_o) busy_q <= 1'b0;
    end
  end

  assert_busy_steps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  assert_done_ends_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  assert_start_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/hilo_regs.sv
module hilo_regs #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hi_we_i,
  input  logic [W-1:0] hi_d_i,
  input  logic         lo_we_i,
  input  logic [W-1:0] lo_d_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= '0;
      lo_o <= '0;
    end else begin
      if (hi_we_i) hi_o <= hi_d_i;
      if (lo_we_i) lo_o <= lo_d_i;
    end
  end

  assert_hi_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_we_i |=> $stable(hi_o));
  assert_lo_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_we_i |=> $stable(lo_o));
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o
);
  mdu_op_e     op;
  logic        accept, is_mul, is_div, is_signed, mul_go, div_start, div_zero;
  logic        div_busy, div_done, hi_we, lo_we, rd_go;
  logic [W-1:0] mul_hi, mul_lo, div_q, div_r, hi_d, lo_d, hi_q, lo_q;

  assign op        = mdu_op_e'(op_i);
  assign accept    = req_valid_i && !div_busy;
  assign is_mul    = (op == OP_MULS) || (op == OP_MULU);
  assign is_div    = (op == OP_DIVS) || (op == OP_DIVU);
  assign is_signed = (op == OP_MULS) || (op == OP_DIVS);
  assign mul_go    = accept && is_mul;
  assign div_zero  = (b_i == '0);
  assign div_start = accept && is_div && !div_zero;
  assign rd_go     = accept && ((op == OP_RDHI) || (op == OP_RDLO));

  hilo_mul #(.W(W)) u_mul (
    .a_i(a_i), .b_i(b_i), .signed_i(is_signed), .hi_o(mul_hi), .lo_o(mul_lo)
  );

  hilo_div #(.W(W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start), .signed_i(is_signed),
    .a_i(a_i), .b_i(b_i), .busy_o(div_busy), .done_o(div_done),
    .quo_o(div_q), .rem_o(div_r)
  );

  always_comb begin
    hi_we = div_done || mul_go || (accept && op == OP_WRHI);
    lo_we = div_done || mul_go || (accept && op == OP_WRLO);
    if (div_done) begin
      hi_d = div_r;
      lo_d = div_q;
    end else if (mul_go) begin
      hi_d = mul_hi;
      lo_d = mul_lo;
    end else begin
      hi_d = a_i;
      lo_d = a_i;
    end
  end

  hilo_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .hi_we_i(hi_we), .hi_d_i(hi_d),
    .lo_we_i(lo_we), .lo_d_i(lo_d), .hi_o(hi_q), .lo_o(lo_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_go;
      if (rd_go) rd_data_o <= (op == OP_RDHI) ? hi_q : lo_q;
    end
  end

  assign busy_o = div_busy;

  assert_no_read_while_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_valid_o);
  assert_div_zero_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_div && div_zero) |=> (!busy_o && $stable(hi_q) && $stable(lo_q)));
  assert_mul_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_go |=> (hi_q == $past(mul_hi) && lo_q == $past(mul_lo)));
  assert_busy_blocks_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !div_done) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: tb/hilo_muldiv_test.sv
module hilo_muldiv_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NV = 15;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] hi;
    logic [31:0] lo;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd1, 32'd3,         32'd5,         32'h00000000, 32'h0000000F},
    '{4'd1, 32'hFFFFFFFE,  32'd3,         32'hFFFFFFFF, 32'hFFFFFFFA},
    '{4'd1, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'h00000000, 32'h00000001},
    '{4'd1, 32'h80000000,  32'h80000000,  32'h40000000, 32'h00000000},
    '{4'd2, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'hFFFFFFFE, 32'h00000001},
    '{4'd2, 32'h00010000,  32'h00010000,  32'h00000001, 32'h00000000},
    '{4'd4, 32'd100,       32'd7,         32'h00000002, 32'h0000000E},
    '{4'd4, 32'hFFFFFFFF,  32'd1,         32'h00000000, 32'hFFFFFFFF},
    '{4'd4, 32'd5,         32'd9,         32'h00000005, 32'h00000000},
    '{4'd4, 32'h80000000,  32'hFFFFFFFF,  32'h80000000, 32'h00000000},
    '{4'd3, 32'hFFFFFFF9,  32'd2,         32'hFFFFFFFF, 32'hFFFFFFFD},
    '{4'd3, 32'd7,         32'hFFFFFFFE,  32'h00000001, 32'hFFFFFFFD},
    '{4'd3, 32'hFFFFFFF9,  32'hFFFFFFFE,  32'hFFFFFFFF, 32'h00000003},
    '{4'd3, 32'h80000000,  32'hFFFFFFFF,  32'h00000000, 32'h80000000},
    '{4'd3, 32'h80000000,  32'd2,         32'h00000000, 32'hC0000000}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic         busy, rd_valid;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  hilo_muldiv #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .op_i(op),
    .a_i(a), .b_i(b), .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act %0d cycles exp <= %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  // one-cycle request; returns at the negedge after the accepting edge
  task automatic issue(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    req_valid = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    req_valid = 1'b0; op = 4'd0; a = '0; b = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_reg(input logic [3:0] o, input string tag, input logic [31:0] exp);
    issue(o, 32'h0, 32'h0);
    chk({tag, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
    chk(tag, rd_data, exp);
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd1: return "R2 signed mul";
      4'd2: return "R3 unsigned mul";
      4'd3: return "R5 signed div";
      default: return "R4 unsigned div";
    endcase
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    read_reg(4'd5, "R1 HI", 32'h0);
    read_reg(4'd6, "R1 LO", 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].a, VECS[i].b);
      chk({tag_of(VECS[i].op), " no rd_valid R7"}, {31'b0, rd_valid}, 32'd0);
      wait_idle();
      read_reg(4'd5, {tag_of(VECS[i].op), " HI"}, VECS[i].hi);
      read_reg(4'd6, {tag_of(VECS[i].op), " LO"}, VECS[i].lo);
    end

    // R4: busy window length
    issue(4'd4, 32'd1000, 32'd3);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R4 busy cycles", n, 32'd32);
    read_reg(4'd6, "R4 LO after busy", 32'd333);
    read_reg(4'd5, "R4 HI after busy", 32'd1);

    // R8: move-to writes one register only
    issue(4'd7, 32'hAAAA0001, 32'h0);
    issue(4'd8, 32'h55550002, 32'h0);
    read_reg(4'd5, "R8 HI", 32'hAAAA0001);
    read_reg(4'd6, "R8 LO", 32'h55550002);

    // R6: divide by zero
    issue(4'd3, 32'd77, 32'd0);
    chk("R6 signed busy", {31'b0, busy}, 32'd0);
    issue(4'd4, 32'd77, 32'd0);
    chk("R6 unsigned busy", {31'b0, busy}, 32'd0);
    read_reg(4'd5, "R6 HI", 32'hAAAA0001);
    read_reg(4'd6, "R6 LO", 32'h55550002);

    // R10: null and undefined ops
    issue(4'd0, 32'h12345678, 32'h9);
    chk("R10 op0 rd_valid", {31'b0, rd_valid}, 32'd0);
    issue(4'd9, 32'h12345678, 32'h9);
    chk("R10 op9 rd_valid", {31'b0, rd_valid}, 32'd0);
    issue(4'd15, 32'h12345678, 32'h9);
    chk("R10 op15 rd_valid", {31'b0, rd_valid}, 32'd0);
    read_reg(4'd5, "R10 HI", 32'hAAAA0001);
    read_reg(4'd6, "R10 LO", 32'h55550002);

    // R9: requests during a divide are refused
    issue(4'd4, 32'd100, 32'd7);
    chk("R9 busy after start", {31'b0, busy}, 32'd1);
    issue(4'd7, 32'hDEADBEEF, 32'h0);
    issue(4'd1, 32'd9, 32'd9);
    issue(4'd6, 32'h0, 32'h0);
    chk("R9 read refused", {31'b0, rd_valid}, 32'd0);
    issue(4'd5, 32'h0, 32'h0);
    chk("R9 read refused 2", {31'b0, rd_valid}, 32'd0);
    wait_idle();
    read_reg(4'd5, "R9 HI", 32'd2);
    read_reg(4'd6, "R9 LO", 32'd14);

    // R7: rd_valid is a single-cycle pulse
    issue(4'd5, 32'h0, 32'h0);
    @(negedge clk);
    chk("R7 pulse drops", {31'b0, rd_valid}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule